// File: doc/BRIEF.md
# Chipset Power State Sequencer

This block walks a host chipset through its hard-off, soft-off, suspend and running power states, and through the transition states that join them. It watches five board-level signals, each passed through a two-flop synchroniser. These are the always-on supply good, the all-rails good, two active-low sleep indications from the chipset, and a flag that says platform reset is still held. It drives the active-low resume reset, the system power-OK and a CPU throttle line. It also reports its current state code.

Every wait is counted in clock cycles and derived from two parameters: clock cycles per microsecond and microseconds per millisecond. Setting the second one small lets a bench run the millisecond delays quickly. Three inputs are taken as already synchronous to the clock: a wake request that leaves hard-off, a force-off request and a pause-in-soft-off configuration bit. The requested throttle level is applied when the chipset is released into the running state, and it is followed while running.

Top module: `pwrseq_top`

## Requirements
- R1: After reset, state is hard-off and resumeRstN, pwrOk and throttle are all 0. The state codes are G3=0, G3S5=1, S5=2, S5S3=3, S3=4, S3S0=5, S0=6, S0S3=7, S3S5=8 and S5G3=9.
- R2: In G3, exitG3Req moves the block to G3S5 at the next edge. In G3S5, once the always-on good is seen, resumeRstN is driven high and the state becomes S5.
- R3: If the always-on good does not arrive within RAIL_TIMEOUT_MS of entering G3S5, the block forces shutdown and returns to G3 with resumeRstN low.
- R4: Each board input reaches the state logic through two flops, so a change shows in the state three edges after it is driven. S5 moves to S5S3 when the S4 sleep input is high, and S5S3 moves on to S3 at the next edge.
- R5: In S3 the checks run in this order. A lost always-on good forces shutdown and goes to S3S5. Otherwise a high S3 sleep input goes to S3S0. Otherwise a low S4 sleep input goes to S3S5.
- R6: In S3S0, once both goods are seen, the block waits SETTLE_MS. It then raises pwrOk, and throttle takes throttleReq at the same edge.
- R7: If both goods are not seen within RAIL_TIMEOUT_MS in S3S0, the block forces shutdown and returns to S3.
- R8: After pwrOk rises, platform reset is sampled at once and then at every millisecond boundary. The first sample that finds it released enters S0. At the sample taken PLTRST_POLLS milliseconds after the rise, the block forces shutdown, clears throttle and returns to S3.
- R9: In S0, a lost good forces shutdown (pwrOk and resumeRstN both low) and goes to S0S3. Otherwise a low S3 sleep input clears pwrOk and goes to S0S3.
- R10: S0S3 keeps pwrOk low for at least 40 ns, then clears throttle and enters S3. resumeRstN is unchanged.
- R11: S3S5 goes to S5 when pauseS5 is 1 and to S5G3 otherwise. S5G3 drives resumeRstN low and enters G3.
- R12: forceReq drives pwrOk and resumeRstN low at the next edge. In S3S0 it also goes to S3; in S0 it also goes to S0S3.
- R13: pwrOk is 0 outside S3S0 and S0. throttle is 0 outside S3S0, S0 and S0S3. While in S0, throttle follows throttleReq one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aoGoodIn | input | 1 | Always-on supply good (asynchronous) |
| allGoodIn | input | 1 | All-rails good (asynchronous) |
| slpS3nIn | input | 1 | Active-low S3 sleep indication (asynchronous) |
| slpS4nIn | input | 1 | Active-low S4 sleep indication (asynchronous) |
| pltrstIn | input | 1 | High while platform reset is asserted (asynchronous) |
| exitG3Req | input | 1 | Request to leave hard-off (synchronous) |
| forceReq | input | 1 | Force-off request (synchronous) |
| pauseS5 | input | 1 | Stop in S5 on the way down |
| throttleReq | input | 1 | Requested throttle level |
| resumeRstN | output | 1 | Active-low resume reset to the chipset |
| pwrOk | output | 1 | System power-OK to the chipset |
| throttle | output | 1 | CPU throttle line |
| stateOut | output | 4 | Current state code |

## Verification
The sequence is driven along every path through the states. These paths are a cold boot, a boot with a missing always-on good, a resume with a missing rail, a resume where platform reset never releases, and a resume where it releases between two samples. Counting cycles between an input change and the output edge separates the synchroniser latency, the settle delay and the millisecond sampling grid, which off-by-one faults would otherwise blur. Driving several inputs together in S3 and in S0 shows which exit condition wins. The resume-reset level shows whether the forced or the orderly branch was taken.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_G3   = 4'd0,
    ST_G3S5 = 4'd1,
    ST_S5   = 4'd2,
    ST_S5S3 = 4'd3,
    ST_S3   = 4'd4,
    ST_S3S0 = 4'd5,
    ST_S0   = 4'd6,
    ST_S0S3 = 4'd7,
    ST_S3S5 = 4'd8,
    ST_S5G3 = 4'd9
  } pstate_e;

  // sub-steps of the resume transition
  typedef enum logic [1:0] {
    PH_RAIL   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_POLL   = 2'd2
  } phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic restart;  // zero all wait counters
    logic rsmSet;   // release resume reset
    logic rsmClr;   // assert resume reset
    logic okSet;    // raise power-OK
    logic okClr;    // drop power-OK
    logic thrLoad;  // take the requested throttle level
    logic thrClr;   // drop throttle
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta;
    logic held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= 1'b0;
        held <= 1'b0;
      end else begin
        meta <= din[i];
        held <= meta;
      end
    end
    assign dout[i] = held;
  end

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int US_PER_MS  = 1000,
  parameter int MS_W       = 8,
  parameter int CYC_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             throttleReq,
  output logic [MS_W-1:0]  msElapsed,
  output logic             msPulse,
  output logic [CYC_W-1:0] cycElapsed,
  output logic             resumeRstN,
  output logic             pwrOk,
  output logic             throttle
);

  localparam int PRE_W = $clog2(CYC_PER_US + 1);
  localparam int US_W  = $clog2(US_PER_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
  localparam logic [US_W-1:0]  US_LAST  = US_W'(US_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_MAX   = '1;
  localparam logic [CYC_W-1:0] CYC_MAX  = '1;

  logic [PRE_W-1:0] presc;
  logic [US_W-1:0]  usCnt;

  // wait timebase: cycles, microsecond prescaler, millisecond count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc      <= '0;
      usCnt      <= '0;
      msElapsed  <= '0;
      msPulse    <= 1'b0;
      cycElapsed <= '0;
    end else if (strobe.restart) begin
      presc      <= '0;
      usCnt      <= '0;
      msElapsed  <= '0;
      msPulse    <= 1'b0;
      cycElapsed <= '0;
    end else begin
      msPulse <= 1'b0;
      if (cycElapsed != CYC_MAX) cycElapsed <= cycElapsed + 1'b1;
      if (presc == PRE_LAST) begin
        presc <= '0;
        if (usCnt == US_LAST) begin
          usCnt   <= '0;
          msPulse <= 1'b1;
          if (msElapsed != MS_MAX) msElapsed <= msElapsed + 1'b1;
        end else begin
          usCnt <= usCnt + 1'b1;
        end
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  // chipset-facing output registers; clears win over sets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeRstN <= 1'b0;
      pwrOk      <= 1'b0;
      throttle   <= 1'b0;
    end else begin
      if (strobe.rsmClr)      resumeRstN <= 1'b0;
      else if (strobe.rsmSet) resumeRstN <= 1'b1;
      if (strobe.okClr)       pwrOk <= 1'b0;
      else if (strobe.okSet)  pwrOk <= 1'b1;
      if (strobe.thrClr)       throttle <= 1'b0;
      else if (strobe.thrLoad) throttle <= throttleReq;
    end
  end

  // the millisecond count never wraps while a wait runs
  assert_ms_saturates_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(msElapsed) == MS_MAX && !$past(strobe.restart)) |-> msElapsed == MS_MAX);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int RAIL_TIMEOUT_MS = 100,
  parameter int SETTLE_MS       = 15,
  parameter int PLTRST_POLLS    = 50,
  parameter int OFF_HOLD_CYC    = 2,
  parameter int MS_W            = 8,
  parameter int CYC_W           = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aoGood,
  input  logic             allGood,
  input  logic             slpS3n,
  input  logic             slpS4n,
  input  logic             pltrstOn,
  input  logic             exitG3Req,
  input  logic             forceReq,
  input  logic             pauseS5,
  input  logic [MS_W-1:0]  msElapsed,
  input  logic             msPulse,
  input  logic [CYC_W-1:0] cycElapsed,
  output pstate_e          state,
  output seqStrobe_t       strobe
);

  localparam logic [MS_W-1:0]  RAIL_LIM   = MS_W'(RAIL_TIMEOUT_MS);
  localparam logic [MS_W-1:0]  SETTLE_LIM = MS_W'(SETTLE_MS);
  localparam logic [MS_W-1:0]  POLL_LIM   = MS_W'(PLTRST_POLLS);
  localparam logic [CYC_W-1:0] HOLD_LIM   = CYC_W'(OFF_HOLD_CYC);

  pstate_e    nextState;
  phase_e     phase, nextPhase;
  seqStrobe_t stb;
  logic       railTimeout;
  logic       pollNow;

  always_comb begin
    nextState   = state;
    nextPhase   = phase;
    stb         = '0;
    railTimeout = (msElapsed >= RAIL_LIM);
    pollNow     = (cycElapsed == '0) || msPulse;
    case (state)
      ST_G3: if (exitG3Req) nextState = ST_G3S5;
      ST_G3S5: begin
        if (aoGood) begin
          stb.rsmSet = 1'b1;
          nextState  = ST_S5;
        end else if (railTimeout) begin
          stb.okClr  = 1'b1;
          stb.rsmClr = 1'b1;
          nextState  = ST_G3;
        end
      end
      ST_S5:   if (slpS4n) nextState = ST_S5S3;
      ST_S5S3: nextState = ST_S3;
      ST_S3: begin
        if (!aoGood) begin
          stb.okClr  = 1'b1;
          stb.rsmClr = 1'b1;
          nextState  = ST_S3S5;
        end else if (slpS3n) begin
          nextState = ST_S3S0;
        end else if (!slpS4n) begin
          nextState = ST_S3S5;
        end
      end
      ST_S3S0: begin
        case (phase)
          PH_RAIL: begin
            if (aoGood && allGood) begin
              nextPhase   = PH_SETTLE;
              stb.restart = 1'b1;
            end else if (railTimeout) begin
              stb.okClr  = 1'b1;
              stb.rsmClr = 1'b1;
              nextState  = ST_S3;
            end
          end
          PH_SETTLE: begin
            if (msElapsed >= SETTLE_LIM) begin
              stb.thrLoad = 1'b1;
              stb.okSet   = 1'b1;
              nextPhase   = PH_POLL;
              stb.restart = 1'b1;
            end
          end
          PH_POLL: begin
            if (pollNow) begin
              if (msElapsed >= POLL_LIM) begin
                stb.okClr  = 1'b1;
                stb.rsmClr = 1'b1;
                stb.thrClr = 1'b1;
                nextState  = ST_S3;
              end else if (!pltrstOn) begin
                nextState = ST_S0;
              end
            end
          end
          default: nextPhase = PH_RAIL;
        endcase
      end
      ST_S0: begin
        stb.thrLoad = 1'b1;
        if (!(aoGood && allGood)) begin
          stb.okClr  = 1'b1;
          stb.rsmClr = 1'b1;
          nextState  = ST_S0S3;
        end else if (!slpS3n) begin
          stb.okClr = 1'b1;
          nextState = ST_S0S3;
        end
      end
      ST_S0S3: begin
        if (cycElapsed >= HOLD_LIM) begin
          stb.thrClr = 1'b1;
          nextState  = ST_S3;
        end
      end
      ST_S3S5: nextState = pauseS5 ? ST_S5 : ST_S5G3;
      ST_S5G3: begin
        stb.rsmClr = 1'b1;
        nextState  = ST_G3;
      end
      default: nextState = ST_G3;
    endcase

    if (forceReq) begin
      stb.okClr  = 1'b1;
      stb.rsmClr = 1'b1;
      if (state == ST_S3S0) begin
        stb.thrClr = 1'b1;
        nextState  = ST_S3;
      end else if (state == ST_S0) begin
        nextState = ST_S0S3;
      end
    end

    if (nextState != state) begin
      stb.restart = 1'b1;
      nextPhase   = PH_RAIL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_G3;
      phase <= PH_RAIL;
    end else begin
      state <= nextState;
      phase <= nextPhase;
    end
  end

  assign strobe = stb;

  assert_s0_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_S0 |=> (state == ST_S0 || state == ST_S0S3));

  assert_s3s5_exit_R11: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_S3S5 |=> (state == ST_S5 || state == ST_S5G3));

  assert_s5g3_exit_R11: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_S5G3 |=> state == ST_G3);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int CYC_PER_US      = 50,
  parameter int US_PER_MS       = 1000,
  parameter int RAIL_TIMEOUT_MS = 100,
  parameter int SETTLE_MS       = 15,
  parameter int PLTRST_POLLS    = 50,
  parameter int OFF_HOLD_NS     = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aoGoodIn,
  input  logic       allGoodIn,
  input  logic       slpS3nIn,
  input  logic       slpS4nIn,
  input  logic       pltrstIn,
  input  logic       exitG3Req,
  input  logic       forceReq,
  input  logic       pauseS5,
  input  logic       throttleReq,
  output logic       resumeRstN,
  output logic       pwrOk,
  output logic       throttle,
  output logic [3:0] stateOut
);

  localparam int MS_LIMIT0 = (RAIL_TIMEOUT_MS > SETTLE_MS) ? RAIL_TIMEOUT_MS : SETTLE_MS;
  localparam int MS_LIMIT  = (MS_LIMIT0 > PLTRST_POLLS) ? MS_LIMIT0 : PLTRST_POLLS;
  localparam int MS_W      = $clog2(MS_LIMIT + 2);
  localparam int HOLD_RAW  = (CYC_PER_US * OFF_HOLD_NS + 999) / 1000;
  localparam int OFF_HOLD  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int CYC_W     = $clog2(OFF_HOLD + 2);

  logic [4:0]       syncOut;
  logic [MS_W-1:0]  msElapsed;
  logic             msPulse;
  logic [CYC_W-1:0] cycElapsed;
  seqStrobe_t       strobe;
  pstate_e          state;

  pwrseq_sync #(.WIDTH(5)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({pltrstIn, slpS4nIn, slpS3nIn, allGoodIn, aoGoodIn}),
    .dout(syncOut)
  );

  pwrseq_ctrl #(
    .RAIL_TIMEOUT_MS(RAIL_TIMEOUT_MS),
    .SETTLE_MS      (SETTLE_MS),
    .PLTRST_POLLS   (PLTRST_POLLS),
    .OFF_HOLD_CYC   (OFF_HOLD),
    .MS_W           (MS_W),
    .CYC_W          (CYC_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .aoGood    (syncOut[0]),
    .allGood   (syncOut[1]),
    .slpS3n    (syncOut[2]),
    .slpS4n    (syncOut[3]),
    .pltrstOn  (syncOut[4]),
    .exitG3Req (exitG3Req),
    .forceReq  (forceReq),
    .pauseS5   (pauseS5),
    .msElapsed (msElapsed),
    .msPulse   (msPulse),
    .cycElapsed(cycElapsed),
    .state     (state),
    .strobe    (strobe)
  );

  pwrseq_dp #(
    .CYC_PER_US(CYC_PER_US),
    .US_PER_MS (US_PER_MS),
    .MS_W      (MS_W),
    .CYC_W     (CYC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .throttleReq(throttleReq),
    .msElapsed  (msElapsed),
    .msPulse    (msPulse),
    .cycElapsed (cycElapsed),
    .resumeRstN (resumeRstN),
    .pwrOk      (pwrOk),
    .throttle   (throttle)
  );

  assign stateOut = state;

  assert_ok_scope_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(state == ST_S3S0 || state == ST_S0) |-> !pwrOk);

  assert_thr_scope_R13: assert property (@(posedge clk) disable iff (!rstN)
    throttle |-> (state == ST_S3S0 || state == ST_S0 || state == ST_S0S3));

  assert_s0_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S0 && $past(state) == ST_S3S0) |-> pwrOk);

  assert_g3_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_G3 |-> !resumeRstN);

  assert_force_R12: assert property (@(posedge clk) disable iff (!rstN)
    forceReq |=> (!pwrOk && !resumeRstN));

endmodule

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;

  localparam int MSC = 20;  // cycles per millisecond with the bench parameters
  localparam int G3 = 0, G3S5 = 1, S5 = 2, S5S3 = 3, S3 = 4, S3S0 = 5,
                 S0 = 6, S0S3 = 7, S3S5 = 8, S5G3 = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aoGoodIn = 1'b0, allGoodIn = 1'b0, slpS3nIn = 1'b0, slpS4nIn = 1'b0;
  logic pltrstIn = 1'b1, exitG3Req = 1'b0, forceReq = 1'b0, pauseS5 = 1'b0;
  logic throttleReq = 1'b0;
  logic resumeRstN, pwrOk, throttle;
  logic [3:0] stateOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwrseq_top #(.CYC_PER_US(2), .US_PER_MS(10)) u0 (
    .clk(clk), .rstN(rstN), .aoGoodIn(aoGoodIn), .allGoodIn(allGoodIn),
    .slpS3nIn(slpS3nIn), .slpS4nIn(slpS4nIn), .pltrstIn(pltrstIn),
    .exitG3Req(exitG3Req), .forceReq(forceReq), .pauseS5(pauseS5),
    .throttleReq(throttleReq), .resumeRstN(resumeRstN), .pwrOk(pwrOk),
    .throttle(throttle), .stateOut(stateOut)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitState(input int tgt, input int maxc, output int n);
    n = 0;
    while (int'(stateOut) != tgt && n < maxc) begin
      step(1);
      n++;
    end
  endtask

  task automatic pulseExit();
    exitG3Req = 1'b1;
    step(1);
    exitG3Req = 1'b0;
  endtask

  task automatic toG3();
    int n;
    slpS3nIn = 1'b0; slpS4nIn = 1'b0; pauseS5 = 1'b0;
    waitState(G3, 200, n);
  endtask

  task automatic bootToS3();
    int n;
    aoGoodIn = 1'b1; slpS3nIn = 1'b0; slpS4nIn = 1'b0;
    step(4);
    pulseExit();
    step(1);
    slpS4nIn = 1'b1;
    waitState(S3, 20, n);
  endtask

  task automatic tReset();
    check("R1 state", stateOut, G3);
    check("R1 resumeRstN", resumeRstN, 0);
    check("R1 pwrOk", pwrOk, 0);
    check("R1 throttle", throttle, 0);
  endtask

  task automatic tG3Timeout();
    int n;
    aoGoodIn = 1'b0;
    pulseExit();
    check("R2 enter G3S5", stateOut, G3S5);
    waitState(G3, 3000, n);
    check("R3 timeout cycles", n, 100 * MSC + 1);
    check("R3 resumeRstN low", resumeRstN, 0);
  endtask

  task automatic tBoot();
    aoGoodIn = 1'b1;
    step(4);
    pulseExit();
    check("R2 G3S5", stateOut, G3S5);
    step(1);
    check("R2 S5", stateOut, S5);
    check("R2 resumeRstN high", resumeRstN, 1);
  endtask

  task automatic tS5Up();
    slpS4nIn = 1'b0;
    step(5);
    check("R4 S5 holds", stateOut, S5);
    slpS4nIn = 1'b1;
    step(2);
    check("R4 sync latency", stateOut, S5);
    step(1);
    check("R4 S5S3", stateOut, S5S3);
    step(1);
    check("R4 S3", stateOut, S3);
    step(5);
    check("R5 S3 holds", stateOut, S3);
  endtask

  task automatic tRailTimeout();
    int n;
    allGoodIn = 1'b0;
    slpS3nIn = 1'b1;
    step(3);
    check("R5 S3 to S3S0", stateOut, S3S0);
    slpS3nIn = 1'b0;
    waitState(S3, 3000, n);
    check("R7 rail timeout cycles", n, 100 * MSC + 1);
    check("R7 pwrOk", pwrOk, 0);
    check("R7 resumeRstN forced", resumeRstN, 0);
  endtask

  task automatic tPause();
    pauseS5 = 1'b1;
    slpS4nIn = 1'b0;
    step(3);
    check("R5 S4 low to S3S5", stateOut, S3S5);
    step(1);
    check("R11 pause to S5", stateOut, S5);
    slpS4nIn = 1'b1;
    step(4);
    check("R4 back to S3", stateOut, S3);
    pauseS5 = 1'b0;
    slpS4nIn = 1'b0;
    step(3);
    check("R11 S3S5", stateOut, S3S5);
    step(1);
    check("R11 no pause S5G3", stateOut, S5G3);
    step(1);
    check("R11 G3", stateOut, G3);
    check("R11 resumeRstN low", resumeRstN, 0);
  endtask

  task automatic tPltrstStuck();
    allGoodIn = 1'b1; throttleReq = 1'b1; pltrstIn = 1'b1;
    step(4);
    slpS3nIn = 1'b1;
    step(3);
    check("R6 S3S0", stateOut, S3S0);
    slpS3nIn = 1'b0;
    step(301);
    check("R6 pwrOk before settle", pwrOk, 0);
    step(1);
    check("R6 pwrOk after settle", pwrOk, 1);
    check("R6 throttle applied", throttle, 1);
    step(1000);
    check("R8 last poll still S3S0", stateOut, S3S0);
    step(1);
    check("R8 watchdog to S3", stateOut, S3);
    check("R8 pwrOk dropped", pwrOk, 0);
    check("R8 throttle cleared", throttle, 0);
    check("R8 resumeRstN forced", resumeRstN, 0);
  endtask

  task automatic tResumeOk();
    int n;
    pltrstIn = 1'b1; throttleReq = 1'b1; slpS3nIn = 1'b1;
    waitState(S3S0, 20, n);
    n = 0;
    while (!pwrOk && n < 1000) begin
      step(1);
      n++;
    end
    step(5 * MSC + 5);
    pltrstIn = 1'b0;
    step(6 * MSC - (5 * MSC + 5));
    check("R8 waits for ms boundary", stateOut, S3S0);
    step(1);
    check("R8 enter S0 on poll", stateOut, S0);
    throttleReq = 1'b0;
    step(1);
    check("R13 throttle follows 0", throttle, 0);
    throttleReq = 1'b1;
    step(1);
    check("R13 throttle follows 1", throttle, 1);
  endtask

  task automatic tS0Sleep();
    slpS3nIn = 1'b0;
    step(2);
    check("R9 S0 before sync", stateOut, S0);
    step(1);
    check("R9 S0S3", stateOut, S0S3);
    check("R10 pwrOk low", pwrOk, 0);
    check("R10 throttle held", throttle, 1);
    step(1);
    check("R10 hold time", stateOut, S0S3);
    step(1);
    check("R10 S3", stateOut, S3);
    check("R10 throttle cleared", throttle, 0);
    check("R10 resumeRstN kept", resumeRstN, 1);
  endtask

  task automatic tS0RailLoss();
    int n;
    slpS3nIn = 1'b1;
    waitState(S0, 1000, n);
    check("R8 quick S0", stateOut, S0);
    allGoodIn = 1'b0;
    slpS3nIn = 1'b0;
    step(3);
    check("R9 rail loss S0S3", stateOut, S0S3);
    check("R9 pwrOk forced", pwrOk, 0);
    check("R9 resumeRstN forced", resumeRstN, 0);
    waitState(S3, 20, n);
    aoGoodIn = 1'b0;
    slpS3nIn = 1'b1;
    step(3);
    check("R5 ao loss beats S3 wake", stateOut, S3S5);
  endtask

  task automatic tForce();
    int n;
    slpS3nIn = 1'b0; slpS4nIn = 1'b0; pauseS5 = 1'b0;
    waitState(G3, 20, n);
    aoGoodIn = 1'b1;
    step(4);
    pulseExit();
    step(1);
    check("R2 S5 again", stateOut, S5);
    forceReq = 1'b1;
    step(1);
    forceReq = 1'b0;
    check("R12 resumeRstN forced", resumeRstN, 0);
    check("R12 pwrOk forced", pwrOk, 0);
    check("R12 state kept", stateOut, S5);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    tReset();
    tG3Timeout();
    tBoot();
    tS5Up();
    tRailTimeout();
    tPause();
    bootToS3();
    tPltrstStuck();
    toG3();
    bootToS3();
    allGoodIn = 1'b1;
    tResumeOk();
    tS0Sleep();
    tS0RailLoss();
    tForce();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule